// File: doc/BRIEF.md
# DS3 Path Data-Link HDLC Receiver

This block recovers HDLC frames carried on the path maintenance data link of a DS3 signal. An upstream framer places one serial bit on `dl_bit` and pulses `dl_strobe` for each of the three data-link slots in the fifth F-frame of every M-frame. Every other cycle is idle, and the value on `dl_bit` is then meaningless. The receiver hunts for the opening flag, drops the zeros that the sender inserted after each run of five ones, and builds octets LSB first. It writes every octet of the frame, including header and checksum octets, to a message buffer through a one-cycle write strobe.

When the closing flag arrives, the receiver pulses end-of-message and reports the result. The result gives the checksum verdict, the command/response bit from the first address octet, and a message-type code decoded from one header octet. A run of seven or more ones aborts the frame in progress. The write pointer returns to the buffer base at every flag and stops at the last of the buffer's 88 locations.

Top module: `dlrx_top`

## Requirements
- R1: Input bits are taken only in cycles where `dl_strobe` is 1. The value of `dl_bit` in any other cycle has no effect on writes or status.
- R2: The octet 0x7E received LSB first is a flag, and it pulses `flag_seen`. A flag that closes a frame containing at least one data bit pulses `eom` two cycles after the final flag strobe. Flags that follow one another directly produce no `eom`. Before the first flag after reset, no octets are written.
- R3: A 0 that follows five consecutive 1s inside a frame is removed and is not part of the data.
- R4: Octets are assembled LSB first. Each completed octet is written with `buf_we` high for one cycle. Writes go to consecutive addresses starting at `BUF_BASE` for the first octet after a flag, and the two checksum octets are also written.
- R5: The write address never leaves the range `BUF_BASE` to `BUF_BASE+BUF_DEPTH-1`, where `BUF_DEPTH` is 88 by default. Once the last location is reached, later octets of the same frame are written to that location.
- R6: The checksum is CRC-16 (reflected polynomial 0x8408, preset 0xFFFF) computed over all frame bits including the sent checksum. A frame is correct when the remainder equals 0xF0B8. `fcs_err` is 0 for a correct frame and 1 otherwise, and it is updated together with `eom`.
- R7: A frame with fewer than 5 octets, or with a bit count that is not a multiple of 8, reports `fcs_err` = 1 at its `eom`.
- R8: Seven or more consecutive 1s inside a frame pulse `abort_seen` once and discard the frame without any `eom`. The receiver then ignores data until the next flag.
- R9: At `eom`, `cr_bit` takes bit 1 of the first octet of the frame.
- R10: At `eom`, `msg_type` gives a code for the octet at header index 3. The codes are 0x38 → 1, 0x34 → 2 and 0x32 → 3. Any other value, or a frame too short to contain that octet, gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dl_bit | input | 1 | Serial data-link bit |
| dl_strobe | input | 1 | Marks a cycle in which `dl_bit` holds a data-link slot |
| buf_we | output | 1 | Message buffer write enable, one cycle per octet |
| buf_addr | output | ADDR_W | Message buffer write address |
| buf_wdata | output | 8 | Octet being written |
| eom | output | 1 | One-cycle pulse when a frame closes |
| fcs_err | output | 1 | Checksum, length or alignment error of the last closed frame |
| flag_seen | output | 1 | One-cycle pulse for each flag |
| abort_seen | output | 1 | One-cycle pulse when a frame is aborted |
| msg_type | output | 2 | Message-type code of the last closed frame |
| cr_bit | output | 1 | Command/response bit of the last closed frame |

## Verification
The bench builds the receiver with `BUF_BASE` = 40, `BUF_DEPTH` = 88 and `TYPE_IDX` = 3. The non-zero base makes a pointer that fails to return to the base, or that wraps toward zero, show up at the ports. With the default depth, one 95-octet frame (97 writes) is enough to reach the end-of-buffer clamp. Header index 3 lets message-type decoding be exercised with both frames long enough to carry the type octet and frames too short to carry it.

// File: rtl/dlrx_pkg.sv
package dlrx_pkg;

    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_RF = 16'h8408;
    localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
    localparam int          MIN_OCTETS  = 5;

    typedef enum logic [1:0] {
        MT_OTHER   = 2'd0,
        MT_PATH_ID = 2'd1,
        MT_IDLE    = 2'd2,
        MT_TEST    = 2'd3
    } msg_type_e;

    function automatic logic [15:0] crc_step(input logic [15:0] crc, input logic b);
        logic fb;
        fb = crc[0] ^ b;
        return fb ? ((crc >> 1) ^ CRC_POLY_RF) : (crc >> 1);
    endfunction

    function automatic msg_type_e decode_type(input logic [7:0] oct);
        case (oct)
            8'h38:   return MT_PATH_ID;
            8'h34:   return MT_IDLE;
            8'h32:   return MT_TEST;
            default: return MT_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/dlrx_bitproc.sv
// Flag and abort detection, zero removal, and a short delay line that holds
// back the bits which may turn out to belong to a closing flag.
module dlrx_bitproc #(
    parameter int HOLD = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bit,
    input  logic in_stb,
    output logic dvld,
    output logic dbit,
    output logic flag_evt,
    output logic abort_evt
);
    localparam int HCNT_W = $clog2(HOLD + 1);

    typedef struct packed {
        logic [2:0]        ones;
        logic              in_frame;
        logic [HOLD-1:0]   hold;
        logic [HCNT_W-1:0] hcnt;
        logic              dvld;
        logic              dbit;
        logic              flag;
        logic              abort;
    } bp_state_t;

    bp_state_t q, d;

    always_comb begin
        logic push;
        logic pbit;
        d       = q;
        d.dvld  = 1'b0;
        d.flag  = 1'b0;
        d.abort = 1'b0;
        push    = 1'b0;
        pbit    = 1'b0;
        if (in_stb) begin
            if (in_bit) begin
                if (q.ones < 3'd5) begin
                    push   = 1'b1;
                    pbit   = 1'b1;
                    d.ones = q.ones + 3'd1;
                end else if (q.ones == 3'd5) begin
                    d.ones = 3'd6;
                end else if (q.ones == 3'd6) begin
                    d.ones     = 3'd7;
                    d.abort    = q.in_frame;
                    d.in_frame = 1'b0;
                    d.hcnt     = '0;
                end
            end else begin
                d.ones = 3'd0;
                if (q.ones == 3'd6) begin
                    d.flag     = 1'b1;
                    d.in_frame = 1'b1;
                    d.hcnt     = '0;
                end else if (q.ones < 3'd5) begin
                    push = 1'b1;
                end
            end
        end
        if (push && q.in_frame) begin
            d.hold = {q.hold[HOLD-2:0], pbit};
            if (q.hcnt == HCNT_W'(HOLD)) begin
                d.dvld = 1'b1;
                d.dbit = q.hold[HOLD-1];
            end else begin
                d.hcnt = q.hcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dvld      = q.dvld;
    assign dbit      = q.dbit;
    assign flag_evt  = q.flag;
    assign abort_evt = q.abort;

endmodule

// File: rtl/dlrx_crc.sv
module dlrx_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic        din,
    output logic [15:0] crc
);
    import dlrx_pkg::*;

    typedef struct packed {
        logic [15:0] rem;
    } crc_state_t;

    crc_state_t q, d;

    always_comb begin
        d = q;
        if (clr)     d.rem = CRC_PRESET;
        else if (en) d.rem = crc_step(q.rem, din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.rem <= CRC_PRESET;
        else        q <= d;
    end

    assign crc = q.rem;

endmodule

// File: rtl/dlrx_top.sv
module dlrx_top #(
    parameter int BUF_BASE  = 0,
    parameter int BUF_DEPTH = 88,
    parameter int ADDR_W    = 9,
    parameter int TYPE_IDX  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dl_bit,
    input  logic              dl_strobe,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic              eom,
    output logic              fcs_err,
    output logic              flag_seen,
    output logic              abort_seen,
    output logic [1:0]        msg_type,
    output logic              cr_bit
);
    import dlrx_pkg::*;

    localparam int              CNT_W  = $clog2(BUF_DEPTH + MIN_OCTETS + TYPE_IDX + 1) + 1;
    localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(BUF_BASE);
    localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(BUF_BASE + BUF_DEPTH - 1);
    localparam logic [CNT_W-1:0]  N_MAX  = '1;

    logic        bp_dvld, bp_dbit, bp_flag, bp_abort;
    logic [15:0] crc_val;

    dlrx_bitproc #(.HOLD(6)) u_bitproc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_bit    (dl_bit),
        .in_stb    (dl_strobe),
        .dvld      (bp_dvld),
        .dbit      (bp_dbit),
        .flag_evt  (bp_flag),
        .abort_evt (bp_abort)
    );

    dlrx_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (bp_flag | bp_abort),
        .en    (bp_dvld),
        .din   (bp_dbit),
        .crc   (crc_val)
    );

    typedef struct packed {
        logic [2:0]        bitcnt;
        logic [7:0]        sr;
        logic [CNT_W-1:0]  nbytes;
        logic [ADDR_W-1:0] ptr;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [7:0]        wdata;
        logic              eom;
        logic              fcs_err;
        logic              flag_seen;
        logic              abort_seen;
        msg_type_e         mtype;
        logic              cr;
        msg_type_e         mtype_acc;
        logic              cr_acc;
    } top_state_t;

    top_state_t q, d;

    always_comb begin
        logic [7:0] oct;
        d            = q;
        d.we         = 1'b0;
        d.eom        = 1'b0;
        d.flag_seen  = 1'b0;
        d.abort_seen = 1'b0;
        oct          = {bp_dbit, q.sr[7:1]};
        if (bp_flag || bp_abort) begin
            if (bp_flag) begin
                d.flag_seen = 1'b1;
                if (q.nbytes != '0 || q.bitcnt != 3'd0) begin
                    d.eom     = 1'b1;
                    d.fcs_err = (q.bitcnt != 3'd0)
                             || (q.nbytes < CNT_W'(MIN_OCTETS))
                             || (crc_val != CRC_RESIDUE);
                    d.mtype   = q.mtype_acc;
                    d.cr      = q.cr_acc;
                end
            end else begin
                d.abort_seen = 1'b1;
            end
            d.bitcnt    = 3'd0;
            d.nbytes    = '0;
            d.ptr       = A_BASE;
            d.mtype_acc = MT_OTHER;
            d.cr_acc    = 1'b0;
        end else if (bp_dvld) begin
            d.sr     = oct;
            d.bitcnt = q.bitcnt + 3'd1;
            if (q.bitcnt == 3'd7) begin
                d.we    = 1'b1;
                d.waddr = q.ptr;
                d.wdata = oct;
                if (q.ptr != A_LAST)      d.ptr    = q.ptr + 1'b1;
                if (q.nbytes != N_MAX)    d.nbytes = q.nbytes + 1'b1;
                if (q.nbytes == '0)       d.cr_acc = oct[1];
                if (q.nbytes == CNT_W'(TYPE_IDX)) d.mtype_acc = decode_type(oct);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.ptr       <= A_BASE;
            q.waddr     <= A_BASE;
            q.mtype     <= MT_OTHER;
            q.mtype_acc <= MT_OTHER;
        end else begin
            q <= d;
        end
    end

    assign buf_we     = q.we;
    assign buf_addr   = q.waddr;
    assign buf_wdata  = q.wdata;
    assign eom        = q.eom;
    assign fcs_err    = q.fcs_err;
    assign flag_seen  = q.flag_seen;
    assign abort_seen = q.abort_seen;
    assign msg_type   = q.mtype;
    assign cr_bit     = q.cr;

endmodule

// File: rtl/dlrx_chk.sv
module dlrx_chk #(
    parameter int BASE   = 0,
    parameter int DEPTH  = 88,
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dl_strobe,
    input logic              bp_dvld,
    input logic              bp_flag,
    input logic              buf_we,
    input logic [ADDR_W-1:0] buf_addr,
    input logic              eom,
    input logic              flag_seen,
    input logic              abort_seen
);
    localparam int LAST = BASE + DEPTH - 1;

    assert_addr_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (int'(buf_addr) >= BASE && int'(buf_addr) <= LAST));

    assert_idle_slot_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dl_strobe |=> (!bp_dvld && !bp_flag));

    assert_eom_from_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eom |-> ($past(bp_flag) && flag_seen));

    assert_abort_no_eom_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_seen |-> !eom);

    assert_write_from_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> $past(bp_dvld));

endmodule

bind dlrx_top dlrx_chk #(
    .BASE   (BUF_BASE),
    .DEPTH  (BUF_DEPTH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dl_strobe  (dl_strobe),
    .bp_dvld    (bp_dvld),
    .bp_flag    (bp_flag),
    .buf_we     (buf_we),
    .buf_addr   (buf_addr),
    .eom        (eom),
    .flag_seen  (flag_seen),
    .abort_seen (abort_seen)
);

// File: tb/dlrx_top_tb.sv
module dlrx_top_tb;
    localparam int BASE  = 40;
    localparam int DEPTH = 88;
    localparam int AW    = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dl_bit = 1'b0;
    logic dl_strobe = 1'b0;
    logic          buf_we;
    logic [AW-1:0] buf_addr;
    logic [7:0]    buf_wdata;
    logic eom, fcs_err, flag_seen, abort_seen, cr_bit;
    logic [1:0] msg_type;

    always #5 clk = ~clk;

    dlrx_top #(.BUF_BASE(BASE), .BUF_DEPTH(DEPTH), .ADDR_W(AW), .TYPE_IDX(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .dl_bit(dl_bit), .dl_strobe(dl_strobe),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .eom(eom), .fcs_err(fcs_err), .flag_seen(flag_seen),
        .abort_seen(abort_seen), .msg_type(msg_type), .cr_bit(cr_bit)
    );

    int n_chk = 0, n_fail = 0;
    int wr_cnt = 0, eom_cnt = 0, abort_cnt = 0, flag_cnt = 0, max_addr = 0;
    logic [7:0] wr_log [0:2047];
    int         ad_log [0:2047];
    logic       last_err;
    logic [1:0] last_type;
    logic       last_cr;

    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_we) begin
                if (wr_cnt < 2048) begin
                    wr_log[wr_cnt] = buf_wdata;
                    ad_log[wr_cnt] = int'(buf_addr);
                end
                if (int'(buf_addr) > max_addr) max_addr = int'(buf_addr);
                wr_cnt++;
            end
            if (eom) begin
                eom_cnt++;
                last_err  = fcs_err;
                last_type = msg_type;
                last_cr   = cr_bit;
            end
            if (abort_seen) abort_cnt++;
            if (flag_seen)  flag_cnt++;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_raw(input logic b);
        @(negedge clk);
        dl_bit = b; dl_strobe = 1'b1;
        @(negedge clk);
        dl_strobe = 1'b0; dl_bit = ~b;
        repeat (2) @(negedge clk);
    endtask

    int ones = 0;

    task automatic send_flag();
        send_raw(1'b0);
        for (int i = 0; i < 6; i++) send_raw(1'b1);
        send_raw(1'b0);
        ones = 0;
    endtask

    task automatic send_dbit(input logic b);
        send_raw(b);
        if (b) begin
            ones++;
            if (ones == 5) begin
                send_raw(1'b0);
                ones = 0;
            end
        end else begin
            ones = 0;
        end
    endtask

    task automatic send_oct(input logic [7:0] o);
        for (int i = 0; i < 8; i++) send_dbit(o[i]);
    endtask

    logic [7:0]  fr [0:127];
    logic [15:0] fcs;

    function automatic logic [15:0] calc_crc(input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {8'h00, fr[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return c;
    endfunction

    task automatic send_frame(input int n, input logic corrupt, input int extra);
        fcs = ~calc_crc(n);
        if (corrupt) fcs = fcs ^ 16'h0004;
        for (int i = 0; i < n; i++) send_oct(fr[i]);
        send_oct(fcs[7:0]);
        send_oct(fcs[15:8]);
        for (int i = 0; i < extra; i++) send_dbit(i[0]);
    endtask

    task automatic build(input int n, input logic [7:0] ty, input logic cr, input int seed);
        for (int i = 0; i < n; i++) begin
            case (i)
                0: fr[i] = 8'h3C | {6'd0, cr, 1'b0};
                1: fr[i] = 8'h01;
                2: fr[i] = 8'h03;
                3: fr[i] = ty;
                default: fr[i] = (ty == 8'hFF) ? 8'hFF : 8'((i * 37 + seed * 11) & 255);
            endcase
        end
    endtask

    // {length, type octet, C/R, corrupt FCS, expected type, expected error}
    localparam int NV = 6;
    localparam logic [20:0] VECS [NV] = '{
        {8'd6,  8'h38, 1'b1, 1'b0, 2'd1, 1'b0},
        {8'd10, 8'h34, 1'b0, 1'b0, 2'd2, 1'b0},
        {8'd4,  8'h32, 1'b1, 1'b1, 2'd3, 1'b1},
        {8'd8,  8'hFF, 1'b0, 1'b0, 2'd0, 1'b0},
        {8'd1,  8'h00, 1'b1, 1'b0, 2'd0, 1'b1},
        {8'd3,  8'h00, 1'b0, 1'b0, 2'd0, 1'b0}
    };

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int w0, e0, a0, mism, len;
        repeat (3) @(negedge clk);
        chk(!buf_we && !eom && !fcs_err && msg_type == 2'd0 && !cr_bit && !flag_seen,
            "reset state", int'({buf_we, eom, fcs_err, msg_type, cr_bit}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: data before the first flag is not written
        send_oct(8'h55); send_oct(8'h0F);
        repeat (4) @(negedge clk);
        chk(wr_cnt == 0, "R2 hunt before first flag", wr_cnt, 0);

        for (int v = 0; v < NV; v++) begin
            len = int'(VECS[v][20:13]);
            build(len, VECS[v][12:5], VECS[v][4], v);
            w0 = wr_cnt; e0 = eom_cnt;
            send_flag();
            send_frame(len, VECS[v][3], 0);
            send_flag();
            repeat (6) @(negedge clk);
            chk(eom_cnt == e0 + 1, "R2 one eom per frame", eom_cnt - e0, 1);
            chk(last_err == VECS[v][0], "R6/R7 fcs_err", int'(last_err), int'(VECS[v][0]));
            chk(last_type == VECS[v][2:1], "R10 msg_type", int'(last_type), int'(VECS[v][2:1]));
            chk(last_cr == VECS[v][4], "R9 cr_bit", int'(last_cr), int'(VECS[v][4]));
            chk(wr_cnt - w0 == len + 2, "R4 write count", wr_cnt - w0, len + 2);
            chk(ad_log[w0] == BASE, "R4 first address", ad_log[w0], BASE);
            mism = 0;
            for (int i = 0; i < len + 2; i++) begin
                logic [7:0] e;
                e = (i < len) ? fr[i] : ((i == len) ? fcs[7:0] : fcs[15:8]);
                if (wr_log[w0 + i] !== e || ad_log[w0 + i] != BASE + i) mism++;
            end
            chk(mism == 0, "R3/R4 octets and addresses", mism, 0);
        end

        // R2: back-to-back flags give flag pulses but no eom
        e0 = eom_cnt; a0 = flag_cnt;
        send_flag(); send_flag();
        repeat (4) @(negedge clk);
        chk(eom_cnt == e0, "R2 empty frame no eom", eom_cnt - e0, 0);
        chk(flag_cnt == a0 + 2, "R2 flag_seen pulses", flag_cnt - a0, 2);

        // R7: trailing bits break octet alignment
        build(6, 8'h38, 1'b0, 9);
        e0 = eom_cnt;
        send_flag(); send_frame(6, 1'b0, 3); send_flag();
        repeat (6) @(negedge clk);
        chk(eom_cnt == e0 + 1 && last_err == 1'b1, "R7 non-octet frame", int'(last_err), 1);

        // R8: abort discards frame, then a good frame is received
        build(6, 8'h34, 1'b1, 4);
        e0 = eom_cnt; a0 = abort_cnt;
        send_flag();
        send_oct(8'h12); send_oct(8'h34);
        for (int i = 0; i < 8; i++) send_raw(1'b1);
        repeat (4) @(negedge clk);
        chk(abort_cnt == a0 + 1, "R8 abort pulse", abort_cnt - a0, 1);
        chk(eom_cnt == e0, "R8 no eom on abort", eom_cnt - e0, 0);
        w0 = wr_cnt;
        send_oct(8'hA5);
        repeat (4) @(negedge clk);
        chk(wr_cnt == w0, "R8 hunt after abort", wr_cnt - w0, 0);
        send_flag(); send_frame(6, 1'b0, 0); send_flag();
        repeat (6) @(negedge clk);
        chk(eom_cnt == e0 + 1 && !last_err && last_type == 2'd2, "R8 recovery frame",
            int'(last_err), 0);

        // R5: long frame clamps at the last buffer location
        build(95, 8'h32, 1'b0, 7);
        w0 = wr_cnt; max_addr = 0;
        send_flag(); send_frame(95, 1'b0, 0); send_flag();
        repeat (6) @(negedge clk);
        chk(wr_cnt - w0 == 97, "R5 long frame writes", wr_cnt - w0, 97);
        chk(max_addr == BASE + DEPTH - 1, "R5 max address", max_addr, BASE + DEPTH - 1);
        chk(ad_log[wr_cnt - 1] == BASE + DEPTH - 1, "R5 clamped address",
            ad_log[wr_cnt - 1], BASE + DEPTH - 1);
        chk(!last_err && last_type == 2'd3, "R6 long frame good", int'(last_err), 0);

        finish_run();
    end
endmodule